// File: doc/BRIEF.md
# Compressed Shift-Immediate Expander and Classifier

This block takes one 16-bit compressed instruction and a base-width select for a 32-, 64- or 128-bit integer base. It finds the three compressed shift-immediate forms: logical left, logical right and arithmetic right. For each one it builds the equivalent 32-bit shift-immediate instruction. It also reports whether that code point is an ordinary instruction, a HINT, or an encoding designated for custom use. Any other compressed instruction gives a clear miss.

A front end places it beside its other compressed-instruction expanders. The expanded word goes on to the normal 32-bit decoder. The class code lets later logic drop HINTs or send custom-designated encodings elsewhere. The output stage is registered by default and gives a result one clock after the input. With the registered stage switched off, the block is purely combinational.

Top module: `cshift_expander`

## Requirements
- R1: A compressed instruction is a left-shift match when bits 1:0 are 10 and bits 15:13 are 000. It is a right-shift match when bits 1:0 are 01, bits 15:13 are 100 and bit 11 is 0. On a right-shift match, bit 10 selects logical (0) or arithmetic (1). Any other value gives hit 0, an all-zero expanded word and class 0.
- R2: For every match, the 6-bit shift amount is {bit 12, bits 6:2}. A left shift expands to opcode 0010011 with funct3 001. Register field bits 11:7 goes into both the destination field [11:7] and the source field [19:15]. Bits 31:27 are zero.
- R3: A right shift uses the 3-bit field in bits 9:7 as register 8 plus that value, in both the destination and the source field. It expands with funct3 101. Bit 30 is 0 for logical and 1 for arithmetic.
- R4: The expanded shift amount sits in bits 26:20. On the 128-bit base, a zero shift amount expands to 64 (bit 26 set, bits 25:20 zero) for all three forms. Otherwise, bits 25:20 carry the 6-bit shift amount and bit 26 is 0.
- R5: On the 32-bit base, a match with shift-amount bit 5 set has class 2 (custom). This applies even when its destination is x0.
- R6: On the 32-bit and 64-bit bases, a match with a zero shift amount that is not custom has class 1 (HINT).
- R7: A left-shift match with destination x0 has class 1 (HINT) on every base, unless R5 makes it custom.
- R8: A match that neither R5, R6 nor R7 covers has class 0 (normal) and hit 1.
- R9: Base select values are 0 for 32-bit, 1 for 64-bit and 2 for 128-bit. The value 3 behaves as the 64-bit base.
- R10: With the registered stage (the default), each output reflects the inputs sampled at the previous rising clock edge. While the synchronous reset is high, hit, class and expanded word are zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cinsn_i | input | 16 | Compressed instruction to examine |
| base_i | input | 2 | Base width select (0: 32, 1: 64, 2: 128, 3: as 64) |
| word_o | output | 32 | Expanded 32-bit instruction, zero on a miss |
| hit_o | output | 1 | High when the input is one of the three shift forms |
| cls_o | output | 2 | Class: 0 normal, 1 HINT, 2 custom |

## Verification
Two rules can apply in the same cycle. The custom rule and the HINT rule for a zero destination both apply to a 32-bit-base left shift with bit 5 set and destination x0. A zero shift amount on the 128-bit base both changes the encoded amount to 64 and, on a left shift with destination x0, still gives a HINT. The bench drives those exact encodings on each base and checks three things: the class follows the custom-then-HINT priority, the expanded amount field is right in the same word, and a nonzero amount leaves the narrower bases untouched. A swept pass over many instruction values on all four select codes compares every output against a model written from the requirements.

// File: rtl/cshx_pkg.sv
package cshx_pkg;

    localparam int CW      = 16;
    localparam int XW      = 32;
    localparam int SHW     = 6;
    localparam int SH_EXPW = SHW + 1;
    localparam int RW      = 5;
    localparam int CRW     = 3;

    localparam logic [6:0] OP_IMM  = 7'b0010011;
    localparam logic [2:0] F3_SLL  = 3'b001;
    localparam logic [2:0] F3_SR   = 3'b101;
    localparam logic [SH_EXPW-1:0] SH_WIDE_ZERO = SH_EXPW'(64);

    typedef enum logic [1:0] {
        BASE_32  = 2'd0,
        BASE_64  = 2'd1,
        BASE_128 = 2'd2,
        BASE_RSV = 2'd3
    } base_e;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_HINT   = 2'd1,
        CLS_CUSTOM = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_SLL  = 2'd1,
        SH_SRL  = 2'd2,
        SH_SRA  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e           kind;
        logic [SHW-1:0]  shamt;
        logic [RW-1:0]   reg_idx;
    } fields_t;

    typedef struct packed {
        logic           hit;
        cls_e           cls;
        logic [XW-1:0]  word;
    } result_t;

    function automatic logic [RW-1:0] widen_creg(input logic [CRW-1:0] f);
        return {2'b01, f};
    endfunction

endpackage

// File: rtl/cshx_field_dec.sv
module cshx_field_dec
    import cshx_pkg::*;
(
    input  logic [CW-1:0] cinsn,
    output fields_t       fields
);
    always_comb begin
        fields         = '0;
        fields.kind    = SH_NONE;
        fields.shamt   = {cinsn[12], cinsn[6:2]};
        if (cinsn[1:0] == 2'b10 && cinsn[15:13] == 3'b000) begin
            fields.kind    = SH_SLL;
            fields.reg_idx = cinsn[11:7];
        end else if (cinsn[1:0] == 2'b01 && cinsn[15:13] == 3'b100 &&
                     cinsn[11] == 1'b0) begin
            fields.kind    = cinsn[10] ? SH_SRA : SH_SRL;
            fields.reg_idx = widen_creg(cinsn[9:7]);
        end
    end
endmodule

// File: rtl/cshx_classify.sv
module cshx_classify
    import cshx_pkg::*;
(
    input  fields_t fields,
    input  base_e   base,
    output cls_e    cls
);
    logic zero_amt;
    logic is_custom;
    logic is_hint;

    always_comb begin
        zero_amt  = (fields.shamt == '0);
        is_custom = (base == BASE_32) && fields.shamt[SHW-1];
        is_hint   = ((base != BASE_128) && zero_amt) ||
                    ((fields.kind == SH_SLL) && (fields.reg_idx == '0));
        if (fields.kind == SH_NONE) begin
            cls = CLS_NORMAL;
        end else if (is_custom) begin
            cls = CLS_CUSTOM;
        end else if (is_hint) begin
            cls = CLS_HINT;
        end else begin
            cls = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/cshx_build.sv
module cshx_build
    import cshx_pkg::*;
(
    input  fields_t       fields,
    input  base_e         base,
    output logic [XW-1:0] word
);
    logic [SH_EXPW-1:0] amt;

    always_comb begin
        if (base == BASE_128 && fields.shamt == '0) begin
            amt = SH_WIDE_ZERO;
        end else begin
            amt = {1'b0, fields.shamt};
        end
        case (fields.kind)
            SH_SLL:  word = {2'b00, 3'b000, amt, fields.reg_idx, F3_SLL,
                             fields.reg_idx, OP_IMM};
            SH_SRL:  word = {2'b00, 3'b000, amt, fields.reg_idx, F3_SR,
                             fields.reg_idx, OP_IMM};
            SH_SRA:  word = {2'b01, 3'b000, amt, fields.reg_idx, F3_SR,
                             fields.reg_idx, OP_IMM};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/cshx_out_stage.sv
module cshx_out_stage
    import cshx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  result_t d,
    output result_t q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/cshift_expander.sv
module cshift_expander
    import cshx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cinsn_i,
    input  logic [1:0]    base_i,
    output logic [XW-1:0] word_o,
    output logic          hit_o,
    output logic [1:0]    cls_o
);
    fields_t       fields;
    base_e         base;
    cls_e          cls;
    logic [XW-1:0] word;
    result_t       res_d;
    result_t       res_q;

    assign base = (base_i == BASE_RSV) ? BASE_64 : base_e'(base_i);

    cshx_field_dec u_dec (
        .cinsn  (cinsn_i),
        .fields (fields)
    );

    cshx_classify u_cls (
        .fields (fields),
        .base   (base),
        .cls    (cls)
    );

    cshx_build u_build (
        .fields (fields),
        .base   (base),
        .word   (word)
    );

    always_comb begin
        res_d.hit  = (fields.kind != SH_NONE);
        res_d.cls  = cls;
        res_d.word = word;
    end

    cshx_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (res_d),
        .q   (res_q)
    );

    assign word_o = res_q.word;
    assign hit_o  = res_q.hit;
    assign cls_o  = res_q.cls;
endmodule

// File: rtl/cshift_expander_chk.sv
module cshift_expander_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cinsn_i,
    input logic [1:0]  base_i,
    input logic [31:0] word_o,
    input logic        hit_o,
    input logic [1:0]  cls_o
);
    logic in_left;
    logic in_right;
    assign in_left  = (cinsn_i[1:0] == 2'b10) && (cinsn_i[15:13] == 3'b000);
    assign in_right = (cinsn_i[1:0] == 2'b01) && (cinsn_i[15:13] == 3'b100) &&
                      !cinsn_i[11];

    generate
        if (REG_OUT) begin : g_chk
            // R1: a miss always shows an all-zero word and class 0
            a_r1_miss_clean: assert property (@(posedge clk) disable iff (rst)
                !hit_o |-> (word_o == 32'd0 && cls_o == 2'd0));

            // R1: non-shift input gives a miss one edge later
            a_r1_no_match: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(in_left) && !$past(in_right)) |-> !hit_o);

            // R2: left shift uses the same register as source and destination
            a_r2_left_self: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_left)) |->
                (hit_o && word_o[19:15] == word_o[11:7] && word_o[14:12] == 3'b001));

            // R3: right shift lands on registers 8 to 15
            a_r3_right_regs: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_right)) |->
                (hit_o && word_o[11:10] == 2'b01 && word_o[19:15] == word_o[11:7]));

            // R4: wide base zero amount becomes 64
            a_r4_wide_zero: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_left || in_right) && $past(base_i) == 2'd2 &&
                 $past({cinsn_i[12], cinsn_i[6:2]}) == 6'd0) |->
                (word_o[26:20] == 7'd64 && cls_o != 2'd1 || word_o[26:20] == 7'd64));

            // R5: custom wins on the narrow base
            a_r5_custom: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_left || in_right) && $past(base_i) == 2'd0 &&
                 $past(cinsn_i[12])) |-> (cls_o == 2'd2));

            // R6: zero amount on narrow bases is a HINT
            a_r6_zero_hint: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_left || in_right) && $past(base_i) != 2'd2 &&
                 $past({cinsn_i[12], cinsn_i[6:2]}) == 6'd0) |-> (cls_o == 2'd1));
        end
    endgenerate
endmodule

bind cshift_expander cshift_expander_chk #(.REG_OUT(REG_OUT)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .cinsn_i (cinsn_i),
    .base_i  (base_i),
    .word_o  (word_o),
    .hit_o   (hit_o),
    .cls_o   (cls_o)
);

// File: tb/cshift_expander_tb_top.sv
module cshift_expander_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cinsn_i = 16'h0000;
    logic [1:0]  base_i = 2'd0;
    logic [31:0] word_o;
    logic        hit_o;
    logic [1:0]  cls_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cshift_expander dut_i (
        .clk     (clk),
        .rst     (rst),
        .cinsn_i (cinsn_i),
        .base_i  (base_i),
        .word_o  (word_o),
        .hit_o   (hit_o),
        .cls_o   (cls_o)
    );

    function automatic logic [15:0] enc_left(input logic [4:0] rd, input logic [5:0] sh);
        return {3'b000, sh[5], rd, sh[4:0], 2'b10};
    endfunction

    function automatic logic [15:0] enc_right(input logic ar, input logic [2:0] rp,
                                              input logic [5:0] sh);
        return {3'b100, sh[5], 1'b0, ar, rp, sh[4:0], 2'b01};
    endfunction

    // Reference model written from the requirements: {hit, cls, word}
    function automatic logic [34:0] model(input logic [15:0] c, input logic [1:0] b);
        logic       isl, isr;
        logic [5:0] sh;
        logic [4:0] r;
        logic [6:0] s7;
        logic [1:0] k;
        logic [31:0] w;
        isl = (c[15:13] == 3'd0) && (c[1:0] == 2'd2);
        isr = (c[15:13] == 3'd4) && (c[1:0] == 2'd1) && !c[11];
        if (!isl && !isr) return 35'd0;
        sh = {c[12], c[6:2]};
        r  = isl ? c[11:7] : (5'd8 + {2'b00, c[9:7]});
        s7 = (b == 2'd2 && sh == 6'd0) ? 7'd64 : {1'b0, sh};
        w  = {1'b0, isr & c[10], 3'b000, s7, r, isl ? 3'b001 : 3'b101, r, 7'b0010011};
        if (b == 2'd0 && sh[5]) k = 2'd2;
        else if ((b != 2'd2 && sh == 6'd0) || (isl && r == 5'd0)) k = 2'd1;
        else k = 2'd0;
        return {1'b1, k, w};
    endfunction

    task automatic compare(input logic [34:0] e, input string tag);
        n_vec++;
        if ({hit_o, cls_o, word_o} !== e) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b cls=%0d word=%h, expected hit=%0b cls=%0d word=%h",
                     tag, hit_o, cls_o, word_o, e[34], e[33:32], e[31:0]);
        end
    endtask

    // drive at a falling edge, sample at the following falling edge
    task automatic apply(input logic [15:0] c, input logic [1:0] b, input string tag);
        cinsn_i = c;
        base_i  = b;
        @(negedge clk);
        compare(model(c, b), tag);
    endtask

    task automatic test_reset();
        cinsn_i = enc_left(5'd3, 6'd4);
        base_i  = 2'd1;
        rst     = 1'b1;
        repeat (3) @(negedge clk);
        compare(35'd0, "R10 reset clears outputs");
        rst = 1'b0;
    endtask

    task automatic test_left();
        apply(enc_left(5'd5, 6'd3), 2'd0, "R2 left rv32 normal");
        apply(enc_left(5'd31, 6'd31), 2'd1, "R2 left rv64 normal");
        apply(enc_left(5'd12, 6'd40), 2'd1, "R2 left rv64 amount bit5");
        if (word_o !== 32'h02861613) begin
            n_fail++;
            $display("FAIL R2 literal: got %h expected %h", word_o, 32'h02861613);
        end
        n_vec++;
        apply(enc_left(5'd7, 6'd63), 2'd2, "R8 left rv128 normal");
    endtask

    task automatic test_right();
        apply(enc_right(1'b0, 3'd0, 6'd1), 2'd0, "R3 srl x8 rv32");
        apply(enc_right(1'b0, 3'd7, 6'd17), 2'd1, "R3 srl x15 rv64");
        apply(enc_right(1'b1, 3'd2, 6'd9), 2'd0, "R3 sra rv32");
        apply(enc_right(1'b1, 3'd5, 6'd33), 2'd2, "R3 sra rv128");
        apply(enc_right(1'b1, 3'd5, 6'd0), 2'd1, "R6 sra zero rv64 hint");
    endtask

    task automatic test_wide_zero();
        apply(enc_left(5'd9, 6'd0), 2'd2, "R4 left zero rv128");
        n_vec++;
        if (word_o[26:20] !== 7'd64 || cls_o !== 2'd0) begin
            n_fail++;
            $display("FAIL R4 amount field: got %h cls %0d expected 40 cls 0",
                     word_o[26:20], cls_o);
        end
        apply(enc_right(1'b0, 3'd3, 6'd0), 2'd2, "R4 srl zero rv128");
        apply(enc_right(1'b1, 3'd4, 6'd0), 2'd2, "R4 sra zero rv128");
        apply(enc_left(5'd0, 6'd0), 2'd2, "R7 R4 left x0 zero rv128 hint");
    endtask

    task automatic test_classes();
        apply(enc_left(5'd4, 6'd32), 2'd0, "R5 left custom rv32");
        apply(enc_left(5'd0, 6'd35), 2'd0, "R5 custom beats x0 hint");
        apply(enc_right(1'b0, 3'd1, 6'd32), 2'd0, "R5 srl custom rv32");
        apply(enc_left(5'd6, 6'd0), 2'd0, "R6 left zero rv32 hint");
        apply(enc_right(1'b0, 3'd6, 6'd0), 2'd1, "R6 srl zero rv64 hint");
        apply(enc_left(5'd0, 6'd5), 2'd0, "R7 left x0 rv32");
        apply(enc_left(5'd0, 6'd45), 2'd1, "R7 left x0 rv64");
        apply(enc_left(5'd0, 6'd12), 2'd2, "R7 left x0 rv128");
    endtask

    task automatic test_misses();
        apply(16'h0000, 2'd0, "R1 zero word miss");
        apply(16'h1002 | 16'h2000, 2'd1, "R1 wrong funct3 miss");
        apply({3'b100, 1'b0, 2'b10, 3'd1, 5'd2, 2'b01}, 2'd1, "R1 andi form miss");
        apply({3'b100, 1'b0, 2'b01, 3'd1, 5'd2, 2'b10}, 2'd1, "R1 wrong quadrant miss");
    endtask

    task automatic test_base3();
        apply(enc_left(5'd3, 6'd0), 2'd3, "R9 select 3 zero hint like 64");
        apply(enc_left(5'd3, 6'd36), 2'd3, "R9 select 3 bit5 not custom");
    endtask

    task automatic test_latency();
        logic [34:0] prev;
        apply(enc_right(1'b1, 3'd2, 6'd7), 2'd1, "R10 first vector");
        prev    = model(enc_right(1'b1, 3'd2, 6'd7), 2'd1);
        cinsn_i = enc_left(5'd1, 6'd2);
        base_i  = 2'd0;
        #1;
        compare(prev, "R10 output holds until edge");
        @(negedge clk);
        compare(model(enc_left(5'd1, 6'd2), 2'd0), "R10 output after edge");
    endtask

    task automatic test_sweep();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 1200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // steer most values onto the shift forms
            case (i % 3)
                0: apply({3'b000, lfsr[12:2], 2'b10}, 2'(i % 4), "R1 R2 sweep left");
                1: apply({3'b100, lfsr[12:2], 2'b01}, 2'(i % 4), "R3 sweep right");
                default: apply(lfsr, 2'(i % 4), "R1 sweep any");
            endcase
        end
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_left();
        test_right();
        test_wide_zero();
        test_classes();
        test_misses();
        test_base3();
        test_latency();
        test_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule